// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps eight sticky interrupt flags for two timer/counters and turns them into interrupt requests. Single-cycle event pulses from the surrounding timer logic set the flags. These pulses are five compare hits, an overflow of the first counter, an input capture, and an overflow of the second counter. The second counter's overflow is special. The block takes two position pulses from that counter, one for "reached TOP and wrapped" and one for "reached BOTTOM". It also takes the counting mode, and the mode decides which of the two pulses sets the flag.

Software reads all eight flags on one byte-wide read port. It clears flags by writing ones, and that clear passes through a synchronisation stage before it acts. The interrupt controller clears one flag at a time by pulsing that flag's acknowledge bit when it takes the matching vector. Each request output is the flag ANDed with its own enable bit and with the global interrupt enable. If a set event and a clear arrive in the same cycle, the set wins, so no event is lost.

Top module: `tmr_irq_flags`

## Requirements
- R1: While reset is asserted and right after it, all eight flag bits read as 0.
- R2: Bit positions, from bit 7 down to bit 0, are: compare 1D, compare 1A, compare 1B, compare 0A, compare 0B, overflow 1, overflow 0, capture 0. The five compare hits come in on `cmp_hit_i[4:0]` in the order {1D,1A,1B,0A,0B}. A pulse on a compare, `ovf0_evt_i` or `cap0_evt_i` input shows up as a 1 in its bit after the next rising edge.
- R3: In count modes 2'b00 (normal) and 2'b01 (fast PWM), the overflow 1 bit sets on a `cnt1_wrap_i` pulse, and `cnt1_bottom_i` has no effect on it.
- R4: In count modes 2'b10 (phase/frequency correct) and 2'b11, the overflow 1 bit sets on a `cnt1_bottom_i` pulse, and `cnt1_wrap_i` has no effect on it.
- R5: An `ack_i[n]` pulse clears bit n at the next rising edge.
- R6: A bus write clears every bit written as 1 at the second rising edge after the write. A read after the first edge still returns the old value.
- R7: Bits written as 0 keep their value.
- R8: If a set event for a bit arrives in the same cycle that an acknowledge or a pending write clear acts on that bit, the bit ends up at 1.
- R9: `irq_o[n]` is 1 exactly when `gie_i`, `irq_en_i[n]` and flag n are all 1. It follows the inputs in the same cycle.
- R10: A set flag stays at 1 until an acknowledge or a write clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_hit_i | input | 5 | Compare-hit pulses {1D,1A,1B,0A,0B} |
| ovf0_evt_i | input | 1 | Overflow pulse of counter 0 |
| cap0_evt_i | input | 1 | Input capture pulse of counter 0 |
| cnt1_mode_i | input | 2 | Counting mode of counter 1 |
| cnt1_wrap_i | input | 1 | Counter 1 reached TOP and reloads BOTTOM this cycle |
| cnt1_bottom_i | input | 1 | Counter 1 reaches BOTTOM this cycle |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data, ones clear flags |
| rd_data_o | output | 8 | Current flag byte |
| ack_i | input | 8 | Per-flag vector-taken acknowledge pulses |
| irq_en_i | input | 8 | Per-flag interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 8 | Interrupt requests |

## Verification
Two things can land on the same flag in one cycle: a set event, and a clear from either an acknowledge or the delayed write. The bench makes the set win in both cases. For the write case, it writes a clear and then pulses one event source exactly in the cycle the clear falls due. For the acknowledge case, it raises the acknowledge in the same cycle as the event. In each case the bit must read 1 afterwards. Every other bit whose clear was pending must read 0, and the expected byte comes from a cycle-level model in the bench.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int FLAG_W = 8;
   localparam int CMP_W  = 5;
   // flag bit positions
   localparam int B_CAP0  = 0;
   localparam int B_OVF0  = 1;
   localparam int B_OVF1  = 2;
   localparam int B_CMP0B = 3;   // cmp_hit_i[0] .. [4] map to bits 3..7
   localparam int B_CMP_LO = B_CMP0B;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_FAST   = 2'd1,
      MODE_PFC    = 2'd2,
      MODE_PFC2   = 2'd3
   } cnt_mode_e;
endpackage

// File: rtl/tmr_ovf_sel.sv
module tmr_ovf_sel
   import tmr_irq_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       wrap_i,
   input  logic       bottom_i,
   output logic       ovf_set_o
);
   cnt_mode_e mode;
   always_comb begin
      mode = cnt_mode_e'(mode_i);
      unique case (mode)
         MODE_NORMAL, MODE_FAST: ovf_set_o = wrap_i;
         default:                ovf_set_o = bottom_i;
      endcase
   end
endmodule

// File: rtl/tmr_wclr_pipe.sv
module tmr_wclr_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] clr_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n)       stg[0] <= '0;
            else if (wr_en_i) stg[0] <= wr_data_i;
            else              stg[0] <= '0;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign clr_o = stg[STAGES-1];
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;   // set has priority
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
   import tmr_irq_pkg::*;
#(
   parameter int CLR_SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMP_W-1:0]  cmp_hit_i,
   input  logic              ovf0_evt_i,
   input  logic              cap0_evt_i,
   input  logic [1:0]        cnt1_mode_i,
   input  logic              cnt1_wrap_i,
   input  logic              cnt1_bottom_i,
   input  logic              wr_en_i,
   input  logic [FLAG_W-1:0] wr_data_i,
   output logic [FLAG_W-1:0] rd_data_o,
   input  logic [FLAG_W-1:0] ack_i,
   input  logic [FLAG_W-1:0] irq_en_i,
   input  logic              gie_i,
   output logic [FLAG_W-1:0] irq_o
);
   localparam int CMP_HI = B_CMP_LO + CMP_W - 1;

   if (CLR_SYNC_STAGES < 1 || CLR_SYNC_STAGES > 4) begin : g_bad_stages
      $error("CLR_SYNC_STAGES must be 1..4");
   end
   if (CMP_HI != FLAG_W - 1) begin : g_bad_layout
      $error("compare bits must fill the top of the flag byte");
   end

   logic              ovf1_set;
   logic [FLAG_W-1:0] set_vec;
   logic [FLAG_W-1:0] clr_pend;
   logic [FLAG_W-1:0] clr_vec;
   logic [FLAG_W-1:0] flags;

   tmr_ovf_sel u_ovf_sel (
      .mode_i    (cnt1_mode_i),
      .wrap_i    (cnt1_wrap_i),
      .bottom_i  (cnt1_bottom_i),
      .ovf_set_o (ovf1_set)
   );

   always_comb begin
      set_vec                 = '0;
      set_vec[CMP_HI:B_CMP_LO] = cmp_hit_i;
      set_vec[B_OVF1]         = ovf1_set;
      set_vec[B_OVF0]         = ovf0_evt_i;
      set_vec[B_CAP0]         = cap0_evt_i;
   end

   tmr_wclr_pipe #(.W(FLAG_W), .STAGES(CLR_SYNC_STAGES)) u_wclr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .clr_o     (clr_pend)
   );

   assign clr_vec = clr_pend | ack_i;

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      tmr_flag_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[i]),
         .clr_i (clr_vec[i]),
         .q_o   (flags[i])
      );
   end

   assign rd_data_o = flags;
   assign irq_o     = flags & irq_en_i & {FLAG_W{gie_i}};
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] set_vec,
   input logic [W-1:0] clr_pend,
   input logic [W-1:0] ack_i,
   input logic         wr_en_i,
   input logic [W-1:0] wr_data_i,
   input logic         gie_i,
   input logic [W-1:0] irq_o,
   input logic [W-1:0] rd_data_o
);
   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_i) |=> ((rd_data_o & $past(ack_i & ~set_vec)) == '0));

   assert_wclr_delayed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && ack_i == '0 && clr_pend == '0) |=>
      ((rd_data_o & $past(wr_data_i & rd_data_o)) == $past(wr_data_i & rd_data_o)));

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((rd_data_o & $past(set_vec)) == $past(set_vec)));

   assert_no_irq_without_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |-> (irq_o == '0));

   assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o & ~rd_data_o) == '0);

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_data_o) & ~rd_data_o & ~$past(ack_i | clr_pend)) == '0);
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.W(tmr_irq_pkg::FLAG_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .set_vec   (set_vec),
   .clr_pend  (clr_pend),
   .ack_i     (ack_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .gie_i     (gie_i),
   .irq_o     (irq_o),
   .rd_data_o (rd_data_o)
);

// File: tb/tmr_irq_flags_tb_top.sv
module tmr_irq_flags_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cmp_hit = '0;
   logic       ovf0_evt = 1'b0, cap0_evt = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       wrap = 1'b0, bottom = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] ack = '0;
   logic [7:0] irq_en = '0;
   logic       gie = 1'b0;
   logic [7:0] irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] exp_flags = '0;
   logic [7:0] exp_pend = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_irq_flags dut_i (
      .clk(clk), .rst_n(rst_n), .cmp_hit_i(cmp_hit), .ovf0_evt_i(ovf0_evt),
      .cap0_evt_i(cap0_evt), .cnt1_mode_i(mode), .cnt1_wrap_i(wrap),
      .cnt1_bottom_i(bottom), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .ack_i(ack), .irq_en_i(irq_en), .gie_i(gie),
      .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: model the edge, drop pulses, compare byte and requests
   task automatic step(input string req);
      logic [7:0] sv;
      @(posedge clk);
      sv = {cmp_hit, (mode[1] ? bottom : wrap), ovf0_evt, cap0_evt};
      exp_flags = (exp_flags & ~(exp_pend | ack)) | sv;
      exp_pend  = wr_en ? wr_data : 8'h00;
      #1;
      cmp_hit = '0; ovf0_evt = 0; cap0_evt = 0; wrap = 0; bottom = 0;
      ack = '0; wr_en = 0; wr_data = '0;
      check(req, rd_data, exp_flags);
      check({req, " irq R9"}, irq, gie ? (exp_flags & irq_en) : 8'h00);
   endtask

   task automatic set_all();
      mode = 2'd0; cmp_hit = 5'h1f; ovf0_evt = 1; cap0_evt = 1; wrap = 1;
      step("R2 set all");
   endtask

   task automatic wclear(input logic [7:0] m, input string req);
      wr_en = 1; wr_data = m;
      step(req);
      step(req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check("R1 in reset", rd_data, 8'h00);
      rst_n = 1'b1;
      step("R1 after reset");

      // R2 / R10 / R5: each direct source, sticky, then acknowledged
      for (int b = 0; b < 8; b++) begin
         if (b == 2) continue;
         if (b >= 3) cmp_hit[b-3] = 1'b1;
         else if (b == 1) ovf0_evt = 1'b1;
         else cap0_evt = 1'b1;
         step("R2 event sets bit");
         check("R2 bit position", rd_data, 8'(1 << b));
         step("R10 sticky"); step("R10 sticky"); step("R10 sticky");
         ack[b] = 1'b1;
         step("R5 ack clears");
         check("R5 ack clears", rd_data, 8'h00);
      end

      // R3 / R4: overflow 1 set point over all modes and pulse combinations
      for (int m = 0; m < 4; m++) begin
         for (int c = 1; c < 4; c++) begin
            mode = 2'(m); wrap = c[0]; bottom = c[1];
            step(m < 2 ? "R3 ovf1 wrap" : "R4 ovf1 bottom");
            check(m < 2 ? "R3 ovf1" : "R4 ovf1", rd_data[2],
                  m < 2 ? c[0] : c[1]);
            ack = 8'h04;
            step("R5 ack ovf1");
         end
      end
      mode = 2'd0;

      // R6 / R7: every write pattern against a full byte
      for (int w = 0; w < 256; w++) begin
         set_all();
         wr_en = 1; wr_data = 8'(w);
         step("R6 old value after first edge");
         check("R6 old value", rd_data, 8'hff);
         step("R6 cleared after second edge");
         check("R7 zeros kept", rd_data, ~8'(w));
         ack = 8'hff;
         step("R5 ack all");
      end

      // R8: set versus pending write clear and versus ack
      for (int b = 0; b < 8; b++) begin
         set_all();
         wr_en = 1; wr_data = 8'hff;
         step("R8 write issued");
         if (b >= 3) cmp_hit[b-3] = 1'b1;
         else if (b == 2) wrap = 1'b1;
         else if (b == 1) ovf0_evt = 1'b1;
         else cap0_evt = 1'b1;
         step("R8 set beats write clear");
         check("R8 write collision", rd_data, 8'(1 << b));
         if (b >= 3) cmp_hit[b-3] = 1'b1;
         else if (b == 2) wrap = 1'b1;
         else if (b == 1) ovf0_evt = 1'b1;
         else cap0_evt = 1'b1;
         ack = 8'hff;
         step("R8 set beats ack");
         check("R8 ack collision", rd_data, 8'(1 << b));
         ack = 8'hff;
         step("R5 ack all");
      end

      // R9: request gating over all enables, both global states
      for (int p = 0; p < 4; p++) begin
         logic [7:0] pat;
         pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hff : (p == 2) ? 8'ha5 : 8'h3c;
         set_all();
         wclear(~pat, "R6 shape pattern");
         for (int e = 0; e < 256; e++) begin
            for (int g = 0; g < 2; g++) begin
               irq_en = 8'(e); gie = g[0];
               #1 check("R9 irq gating", irq, g[0] ? (pat & 8'(e)) : 8'h00);
            end
         end
         ack = 8'hff;
         step("R5 ack all");
      end
      gie = 0; irq_en = '0;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule